// File: doc/BRIEF.md
# Event-Driven GPIO Output Action Unit

This block holds a 32-bit GPIO output register whose bits can be changed by hardware event lines without any CPU involvement. There are four event channels. Each channel has one byte in a 32-bit configuration word. That byte holds an enable bit, a two-bit action code and a five-bit pin index. An enabled channel can make its selected output bit follow the event level, or it can set, clear or invert that bit when an event pulse arrives.

Software has two write ports. One writes the configuration word. A lock input can block writes to that word. The other write port loads the whole output register at once. When a software write and an event action hit the same bit in the same cycle, the event action wins. Pad drivers, input sampling, direction control and event routing lie outside the block.

Top module: `evgpio_action_unit`

## Requirements
- R1: While reset is active, and right after it, the configuration readback and the pin outputs are all zero. Every channel is therefore disabled.
- R2: A configuration write with the lock low stores the write data. The stored word appears on the readback port one cycle later, and the readback always returns the stored word.
- R3: While the lock input is high, configuration writes are ignored and the stored word does not change.
- R4: Channel c uses bits 8c+7..8c of the configuration word. Bit 8c+7 is its enable. When the enable is 0, events on channel c do not change any output bit.
- R5: Bits 8c+6..8c+5 hold the action code. Code 0 copies the event level into the pin on every cycle the channel is enabled. Codes 1, 2 and 3 act only in a cycle where the event is high: 1 sets the pin, 2 clears it, 3 inverts it.
- R6: Bits 8c+4..8c+0 select the target output bit, from 0 to 31.
- R7: Enabled channels that target different pins all take effect in the same cycle.
- R8: A channel has a pending action when it is enabled and either its code is 0 or its event is high. When several channels with a pending action target one pin in the same cycle, the highest-numbered of them decides that pin.
- R9: An output write loads all 32 output bits. In the same cycle, any bit that a pending event action targets takes the event's result instead.
- R10: Event actions and software writes take effect on the next clock edge. That edge uses the configuration stored before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_lock_i | input | 1 | Write protection for the configuration word |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Stored configuration word |
| out_wr_i | input | 1 | Output register write strobe |
| out_wdata_i | input | 32 | Output register write data |
| evt_i | input | 4 | Event lines, one per channel |
| pin_out_o | output | 32 | Output register value |

## Verification
The assertions check four things on every cycle:
- a locked write leaves the configuration word unchanged, and an unlocked write shows up on the readback;
- with every channel disabled and no output write, the outputs hold;
- the top channel, which can never be overridden, always decides its own pin.

Other behaviour depends on how channels interact, and only the bench scenarios can show it. This covers priority among lower channels on a shared pin, inversion from the previous value, and the event-over-software rule on colliding bits. The bench checks these against a reference function, using directed cases and seeded random traffic.

// File: rtl/evgpio_pkg.sv
package evgpio_pkg;
  localparam int SLOT_W = 8;
  typedef enum logic [1:0] {
    ACT_LEVEL = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLR   = 2'd2,
    ACT_TGL   = 2'd3
  } act_e;
endpackage

// File: rtl/evgpio_cfg_reg.sv
module evgpio_cfg_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             lock_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] cfg_o
);
  logic [WIDTH-1:0] cfg_d, cfg_q;
  logic             cfg_en;

  always_comb begin
    cfg_en = wr_i & ~lock_i;
    cfg_d  = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/evgpio_chan_decode.sv
module evgpio_chan_decode
  import evgpio_pkg::*;
#(
  parameter int NUM_PIN = 32,
  parameter int PID_W   = $clog2(NUM_PIN)
) (
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic               evt_i,
  output logic [NUM_PIN-1:0] hit_o,
  output logic [1:0]         act_o
);
  logic             enable;
  logic             pending;
  logic [PID_W-1:0] pid;

  always_comb begin
    enable  = slot_i[SLOT_W-1];
    act_o   = slot_i[6:5];
    pid     = slot_i[PID_W-1:0];
    pending = enable & ((act_e'(act_o) == ACT_LEVEL) | evt_i);
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    assign hit_o[p] = pending && (pid == PID_W'(p));
  end
endmodule

// File: rtl/evgpio_out_merge.sv
module evgpio_out_merge
  import evgpio_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_PIN = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CH-1:0][NUM_PIN-1:0]   hit_i,
  input  logic [NUM_CH-1:0][1:0]           act_i,
  input  logic [NUM_CH-1:0]                evt_i,
  input  logic                             sw_wr_i,
  input  logic [NUM_PIN-1:0]               sw_wdata_i,
  output logic [NUM_PIN-1:0]               out_o
);
  logic [NUM_PIN-1:0] out_d, out_q;
  logic               out_en;
  logic               any_hit;

  always_comb begin
    any_hit = |hit_i;
    out_en  = sw_wr_i | any_hit;
    for (int p = 0; p < NUM_PIN; p++) begin
      out_d[p] = sw_wr_i ? sw_wdata_i[p] : out_q[p];
      // ascending scan: the last (highest) pending channel decides the pin
      for (int c = 0; c < NUM_CH; c++) begin
        if (hit_i[c][p]) begin
          unique case (act_e'(act_i[c]))
            ACT_LEVEL: out_d[p] = evt_i[c];
            ACT_SET:   out_d[p] = 1'b1;
            ACT_CLR:   out_d[p] = 1'b0;
            ACT_TGL:   out_d[p] = ~out_q[p];
            default:   out_d[p] = out_q[p];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  assign out_o = out_q;
endmodule

// File: rtl/evgpio_action_unit.sv
module evgpio_action_unit
  import evgpio_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_PIN = 32,
  localparam int CFG_W  = NUM_CH * SLOT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic               cfg_lock_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W-1:0]   cfg_rdata_o,
  input  logic               out_wr_i,
  input  logic [NUM_PIN-1:0] out_wdata_i,
  input  logic [NUM_CH-1:0]  evt_i,
  output logic [NUM_PIN-1:0] pin_out_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [CFG_W-1:0]                 cfg;
  logic [NUM_CH-1:0][NUM_PIN-1:0]   hit;
  logic [NUM_CH-1:0][1:0]           act;

  evgpio_cfg_reg #(.WIDTH(CFG_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .wr_i    (cfg_wr_i),
    .lock_i  (cfg_lock_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evgpio_chan_decode #(.NUM_PIN(NUM_PIN)) u_dec (
      .slot_i (cfg[c*SLOT_W +: SLOT_W]),
      .evt_i  (evt_i[c]),
      .hit_o  (hit[c]),
      .act_o  (act[c])
    );
  end

  evgpio_out_merge #(.NUM_CH(NUM_CH), .NUM_PIN(NUM_PIN)) u_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .hit_i      (hit),
    .act_i      (act),
    .evt_i      (evt_i),
    .sw_wr_i    (out_wr_i),
    .sw_wdata_i (out_wdata_i),
    .out_o      (pin_out_o)
  );

  assign cfg_rdata_o = cfg;
endmodule

// File: rtl/evgpio_checker.sv
module evgpio_checker #(
  parameter int NUM_CH  = 4,
  parameter int NUM_PIN = 32,
  localparam int CFG_W  = NUM_CH * 8,
  localparam int HI     = (NUM_CH - 1) * 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_wr_i,
  input logic               cfg_lock_i,
  input logic [CFG_W-1:0]   cfg_wdata_i,
  input logic [CFG_W-1:0]   cfg_rdata_o,
  input logic               out_wr_i,
  input logic [NUM_CH-1:0]  evt_i,
  input logic [NUM_PIN-1:0] pin_out_o
);
  logic [CFG_W-1:0] en_mask;
  always_comb begin
    en_mask = '0;
    for (int c = 0; c < NUM_CH; c++) en_mask[c*8+7] = 1'b1;
  end

  assert_locked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_lock_i) |=> $stable(cfg_rdata_o));

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && !cfg_lock_i) |=> (cfg_rdata_o == $past(cfg_wdata_i)));

  assert_disabled_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cfg_rdata_o & en_mask) == '0) && !out_wr_i) |=> $stable(pin_out_o));

  assert_top_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[HI+7] && cfg_rdata_o[HI+6:HI+5] == 2'd0)
      |=> (pin_out_o[$past(cfg_rdata_o[HI+4:HI])] == $past(evt_i[NUM_CH-1])));

  assert_top_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[HI+7] && cfg_rdata_o[HI+6:HI+5] == 2'd1 && evt_i[NUM_CH-1])
      |=> pin_out_o[$past(cfg_rdata_o[HI+4:HI])]);
endmodule

bind evgpio_action_unit evgpio_checker #(.NUM_CH(NUM_CH), .NUM_PIN(NUM_PIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_lock_i  (cfg_lock_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .out_wr_i    (out_wr_i),
  .evt_i       (evt_i),
  .pin_out_o   (pin_out_o)
);

// File: tb/evgpio_action_unit_test.sv
module evgpio_action_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_lock, out_wr;
  logic [31:0] cfg_wdata, out_wdata, cfg_rdata, pin_out;
  logic [3:0]  evt;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] m_cfg, m_out;

  always #4 clk = ~clk;

  evgpio_action_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_lock_i(cfg_lock),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .out_wr_i(out_wr),
    .out_wdata_i(out_wdata), .evt_i(evt), .pin_out_o(pin_out)
  );

  function automatic logic [7:0] mk(logic en, logic [1:0] act, logic [4:0] pid);
    return {en, act, pid};
  endfunction

  function automatic logic [31:0] ref_out(logic [31:0] q, logic [31:0] cfg,
      logic [3:0] ev, logic wr, logic [31:0] wd);
    logic [31:0] r;
    r = wr ? wd : q;
    for (int c = 0; c < 4; c++) begin
      logic [7:0] b;
      b = cfg[c*8 +: 8];
      if (b[7] && (b[6:5] == 2'd0 || ev[c])) begin
        case (b[6:5])
          2'd0: r[b[4:0]] = ev[c];
          2'd1: r[b[4:0]] = 1'b1;
          2'd2: r[b[4:0]] = 1'b0;
          default: r[b[4:0]] = ~q[b[4:0]];
        endcase
      end
    end
    return r;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(string tag, logic cw, logic lk, logic [31:0] cd,
      logic ow, logic [31:0] od, logic [3:0] ev);
    logic [31:0] nc, no;
    cfg_wr = cw; cfg_lock = lk; cfg_wdata = cd;
    out_wr = ow; out_wdata = od; evt = ev;
    nc = (cw && !lk) ? cd : m_cfg;
    no = ref_out(m_out, m_cfg, ev, ow, od);
    @(posedge clk);
    @(negedge clk);
    m_cfg = nc; m_out = no;
    check(tag, "cfg", cfg_rdata, m_cfg);
    check(tag, "out", pin_out, m_out);
  endtask

  task automatic idle(string tag);
    drive(tag, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 4'h0);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    rst_n = 1'b0; cfg_wr = 0; cfg_lock = 0; cfg_wdata = 0;
    out_wr = 0; out_wdata = 0; evt = 0;
    m_cfg = 0; m_out = 0;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1", "cfg in reset", cfg_rdata, 32'h0);
    check("R1", "out in reset", pin_out, 32'h0);
    rst_n = 1'b1;
    repeat (3) idle("R1");

    // R2: unlocked write, ch0 set pin 5
    drive("R2", 1, 0, {24'h0, mk(1, 2'd1, 5'd5)}, 0, 0, 4'h0);
    // R6: event on ch0 sets bit 5
    drive("R6", 0, 0, 0, 0, 0, 4'b0001);
    check("R6", "bit5", pin_out, 32'h0000_0020);
    // R3: locked write ignored
    drive("R3", 1, 1, 32'hFFFF_FFFF, 0, 0, 4'h0);
    check("R3", "cfg kept", cfg_rdata, {24'h0, mk(1, 2'd1, 5'd5)});
    // R4: disabled channel ignores events
    drive("R4", 1, 0, {24'h0, mk(0, 2'd1, 5'd9)}, 0, 0, 4'h0);
    drive("R4", 0, 0, 0, 0, 0, 4'b0001);
    check("R4", "no change", pin_out, 32'h0000_0020);
    // R5: toggle on ch1 pin 3, twice
    drive("R5", 1, 0, {16'h0, mk(1, 2'd3, 5'd3), 8'h00}, 0, 0, 4'h0);
    drive("R5", 0, 0, 0, 0, 0, 4'b0010);
    check("R5", "tgl on", pin_out, 32'h0000_0028);
    drive("R5", 0, 0, 0, 0, 0, 4'b0010);
    check("R5", "tgl off", pin_out, 32'h0000_0020);
    // R5: level copy on ch2 pin 7
    drive("R5", 1, 0, {8'h0, mk(1, 2'd0, 5'd7), 16'h0}, 0, 0, 4'h0);
    drive("R5", 0, 0, 0, 0, 0, 4'b0100);
    check("R5", "level hi", pin_out[7], 32'(1'b1));
    drive("R5", 0, 0, 0, 0, 0, 4'b0000);
    check("R5", "level lo", pin_out[7], 32'(1'b0));
    // R7: two channels, different pins, same cycle
    drive("R7", 1, 0, {16'h0, mk(1, 2'd2, 5'd5), mk(1, 2'd1, 5'd1)}, 0, 0, 4'h0);
    drive("R7", 0, 0, 0, 0, 0, 4'b0011);
    check("R7", "both", pin_out, 32'h0000_0002);
    // R8: ch0 set and ch3 clear on pin 10; ch3 wins
    drive("R8", 1, 0, {mk(1, 2'd2, 5'd10), 16'h0, mk(1, 2'd1, 5'd10)}, 0, 0, 4'h0);
    drive("R8", 0, 0, 0, 1, 32'h0000_0400, 4'b1001);
    check("R8", "top wins", pin_out[10], 32'(1'b0));
    // R8: ch3 not pending, lower channel acts
    drive("R8", 0, 0, 0, 0, 0, 4'b0001);
    check("R8", "lower acts", pin_out[10], 32'(1'b1));
    // R9: software write vs event clear on pin 4
    drive("R9", 1, 0, {16'h0, mk(1, 2'd2, 5'd4), 8'h00}, 0, 0, 4'h0);
    drive("R9", 0, 0, 0, 1, 32'hFFFF_FFFF, 4'b0010);
    check("R9", "event wins", pin_out, 32'hFFFF_FFEF);
    // R10: new config and event same cycle use old config (ch1 clear pin 4)
    drive("R10", 1, 0, {16'h0, mk(1, 2'd1, 5'd4), 8'h00}, 1, 32'h0000_0010, 4'b0010);
    check("R10", "old cfg", pin_out[4], 32'(1'b0));

    // random traffic against the reference function (R5, R7, R8, R9)
    for (int i = 0; i < 4000; i++) begin
      logic cw, lk, ow;
      cw = ($urandom % 6) == 0;
      lk = ($urandom % 4) == 0;
      ow = ($urandom % 8) == 0;
      drive("R8", cw, lk, $urandom & 32'hFF9F_FF9F | ($urandom & 32'h0060_0060),
            ow, $urandom, 4'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule